// File: doc/BRIEF.md
# Prefix-Extended Nibble Instruction Decoder

This block fetches a byte-wide instruction stream one byte at a time and carries out each byte against a three-deep register evaluation stack and a fixed workspace pointer. Every byte holds a 4-bit function code in its upper half and a 4-bit immediate in its lower half. Two prefix functions chain nibbles into a hidden operand register, so that the next instruction sees a wider constant. One function treats the built operand as an extended opcode with no operand of its own.

The instruction memory and the data memory sit outside the block. Both are synchronous: a request issued in one cycle returns its data in the next. Load and store local address data words at the workspace pointer plus the operand. The implemented subset is jump, two prefixes, load constant, load local, add constant, store local and operate, where operate knows reverse, add and subtract. Any other code stops the block with an error flag until reset.

Top module: `nibble_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, the stack outputs read zero, `error` is low and `imem_addr` equals the parameter `IPTR_RESET` (default 0).
- R2: Byte bits 7:4 select the function and bits 3:0 are the immediate. Function 0x4 (load constant) pushes the operand: C takes B, B takes A, A takes the operand.
- R3: Function 0x2 (positive prefix) ORs its nibble into the operand register and shifts the result left by 4, so 0x21 0x22 0x43 loads 0x123.
- R4: Function 0x6 (negative prefix) ORs its nibble, inverts every bit and then shifts left by 4, so 0x61 0x45 loads 0xFFFFFFE5.
- R5: Every instruction other than a prefix clears the operand register after use, so a prefix affects only the next non-prefix instruction.
- R6: Function 0x8 (add constant) replaces A with A plus the operand, modulo 2^32, and leaves B and C unchanged.
- R7: Function 0x7 (load local) reads the data word at `WPTR_RESET` plus the operand and pushes it. It takes three cycles from its fetch request to the next fetch request.
- R8: Function 0xD (store local) writes A to the data word at `WPTR_RESET` plus the operand, then pops: A takes B, B takes C, and C keeps its value.
- R9: Function 0x0 (jump) sets the instruction address to the address of the following byte plus the operand, taken as a two's-complement value. The stack is left unchanged.
- R10: Function 0xF (operate) with operand 0x00 exchanges A and B.
- R11: Operate 0x05 replaces A with B plus A. Operate 0x0C replaces A with B minus A. In both cases B takes C and C keeps its value.
- R12: An operate code other than 0x00, 0x05 or 0x0C, or a function code outside the set above, raises `error`. The error stays high until reset. The block issues no further fetch or data access, leaves the stack unchanged and holds `imem_addr` at the faulting byte.
- R13: Every instruction other than load local takes two cycles: a fetch request, then an execute cycle whose results are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| imem_req | output | 1 | Instruction fetch request |
| imem_addr | output | IADDR_W | Byte address of the current instruction |
| imem_rdata | input | 8 | Instruction byte, valid the cycle after a request |
| dmem_re | output | 1 | Data read request |
| dmem_we | output | 1 | Data write strobe |
| dmem_addr | output | DADDR_W | Data word address |
| dmem_wdata | output | DATA_W | Data write value (stack top) |
| dmem_rdata | input | DATA_W | Data read value, valid the cycle after a read request |
| stk_a | output | DATA_W | Stack top register |
| stk_b | output | DATA_W | Second stack register |
| stk_c | output | DATA_W | Bottom stack register |
| error | output | 1 | Undefined code seen; fetch halted |

## Verification
Results of an ordinary instruction appear two cycles after its fetch request: the byte arrives in the execute cycle and the registers update on that cycle's closing edge. Load local adds a third cycle for the data word. Directed tests find the first fetch request after reset at a falling edge, then check the stack both in the execute cycle, where it must not have changed yet, and one falling edge later. Table-driven programs end in a two-byte loop that does not touch the stack, so the final stack values are sampled after a fixed margin, when they are known to be stable.

// File: rtl/nid_pkg.sv
package nid_pkg;
  localparam logic [3:0] FN_J    = 4'h0;
  localparam logic [3:0] FN_PFIX = 4'h2;
  localparam logic [3:0] FN_LDC  = 4'h4;
  localparam logic [3:0] FN_NFIX = 4'h6;
  localparam logic [3:0] FN_LDL  = 4'h7;
  localparam logic [3:0] FN_ADC  = 4'h8;
  localparam logic [3:0] FN_STL  = 4'hD;
  localparam logic [3:0] FN_OPR  = 4'hF;

  localparam int OP_REV = 'h00;
  localparam int OP_ADD = 'h05;
  localparam int OP_SUB = 'h0C;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_EXEC,
    ST_LOAD,
    ST_HALT
  } state_t;

  typedef enum logic [2:0] {
    STK_HOLD,
    STK_PUSH,
    STK_POP,
    STK_SWAP,
    STK_TOPSET,
    STK_POPSET
  } stk_op_t;
endpackage

// File: rtl/nid_operand.sv
module nid_operand
  import nid_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [3:0]        fn,
  input  logic [3:0]        nibble,
  output logic [DATA_W-1:0] opnd
);
  logic [DATA_W-1:0] oreg_q;
  logic [DATA_W-1:0] oreg_d;
  logic              oreg_en;

  assign opnd    = oreg_q | DATA_W'(nibble);
  assign oreg_en = step;

  always_comb begin
    oreg_d = '0;
    if (fn == FN_PFIX) begin
      oreg_d = opnd << 4;
    end else if (fn == FN_NFIX) begin
      oreg_d = (~opnd) << 4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oreg_q <= '0;
    end else if (oreg_en) begin
      oreg_q <= oreg_d;
    end
  end

  // R5: a non-prefix instruction leaves nothing above the nibble field
  assert_operand_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fn != FN_PFIX && fn != FN_NFIX) |=> (opnd[DATA_W-1:4] == '0));
endmodule

// File: rtl/nid_stack.sv
module nid_stack
  import nid_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_t           op,
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] c
);
  logic [DATA_W-1:0] a_d, b_d, c_d;
  logic              stk_en;

  assign stk_en = (op != STK_HOLD);

  always_comb begin
    a_d = a;
    b_d = b;
    c_d = c;
    unique case (op)
      STK_PUSH: begin
        a_d = val;
        b_d = a;
        c_d = b;
      end
      STK_POP: begin
        a_d = b;
        b_d = c;
      end
      STK_SWAP: begin
        a_d = b;
        b_d = a;
      end
      STK_TOPSET: a_d = val;
      STK_POPSET: begin
        a_d = val;
        b_d = c;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a <= '0;
      b <= '0;
      c <= '0;
    end else if (stk_en) begin
      a <= a_d;
      b <= b_d;
      c <= c_d;
    end
  end

  assert_push_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_PUSH) |=> (b == $past(a) && c == $past(b)));

  assert_pop_keeps_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_POP) |=> (a == $past(b) && c == $past(c)));

  assert_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == STK_SWAP) |=> (a == $past(b) && b == $past(a) && c == $past(c)));
endmodule

// File: rtl/nid_ctrl.sv
module nid_ctrl
  import nid_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IADDR_W    = 16,
  parameter int DADDR_W    = 16,
  parameter int IPTR_RESET = 0,
  parameter int WPTR_RESET = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         imem_rdata,
  input  logic [DATA_W-1:0]  dmem_rdata,
  input  logic [DATA_W-1:0]  opnd,
  input  logic [DATA_W-1:0]  stk_a,
  input  logic [DATA_W-1:0]  stk_b,
  output logic               imem_req,
  output logic [IADDR_W-1:0] imem_addr,
  output logic               dmem_re,
  output logic               dmem_we,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  output logic               step,
  output logic [3:0]         fn,
  output logic [3:0]         nibble,
  output stk_op_t            stk_op,
  output logic [DATA_W-1:0]  stk_val,
  output logic               error
);
  localparam logic [DATA_W-1:0]  OPC_REV = DATA_W'(OP_REV);
  localparam logic [DATA_W-1:0]  OPC_ADD = DATA_W'(OP_ADD);
  localparam logic [DATA_W-1:0]  OPC_SUB = DATA_W'(OP_SUB);
  localparam logic [DADDR_W-1:0] WPTR    = DADDR_W'(WPTR_RESET);
  localparam logic [IADDR_W-1:0] IPTR0   = IADDR_W'(IPTR_RESET);

  state_t             state_q, state_d;
  logic [IADDR_W-1:0] iptr_q, iptr_d, iptr_inc;
  logic               iptr_en;

  assign fn         = imem_rdata[7:4];
  assign nibble     = imem_rdata[3:0];
  assign step       = (state_q == ST_EXEC);
  assign imem_req   = (state_q == ST_FETCH);
  assign error      = (state_q == ST_HALT);
  assign imem_addr  = iptr_q;
  assign iptr_inc   = iptr_q + IADDR_W'(1);
  assign dmem_addr  = WPTR + opnd[DADDR_W-1:0];
  assign dmem_wdata = stk_a;

  always_comb begin
    state_d = state_q;
    iptr_d  = iptr_inc;
    iptr_en = 1'b0;
    stk_op  = STK_HOLD;
    stk_val = opnd;
    dmem_re = 1'b0;
    dmem_we = 1'b0;
    unique case (state_q)
      ST_FETCH: state_d = ST_EXEC;
      ST_EXEC: begin
        state_d = ST_FETCH;
        iptr_en = 1'b1;
        unique case (fn)
          FN_J:    iptr_d = iptr_inc + opnd[IADDR_W-1:0];
          FN_PFIX, FN_NFIX: ;
          FN_LDC:  stk_op = STK_PUSH;
          FN_LDL: begin
            dmem_re = 1'b1;
            state_d = ST_LOAD;
          end
          FN_ADC: begin
            stk_op  = STK_TOPSET;
            stk_val = stk_a + opnd;
          end
          FN_STL: begin
            dmem_we = 1'b1;
            stk_op  = STK_POP;
          end
          FN_OPR: begin
            if (opnd == OPC_REV) begin
              stk_op = STK_SWAP;
            end else if (opnd == OPC_ADD) begin
              stk_op  = STK_POPSET;
              stk_val = stk_b + stk_a;
            end else if (opnd == OPC_SUB) begin
              stk_op  = STK_POPSET;
              stk_val = stk_b - stk_a;
            end else begin
              iptr_en = 1'b0;
              state_d = ST_HALT;
            end
          end
          default: begin
            iptr_en = 1'b0;
            state_d = ST_HALT;
          end
        endcase
      end
      ST_LOAD: begin
        stk_op  = STK_PUSH;
        stk_val = dmem_rdata;
        state_d = ST_FETCH;
      end
      ST_HALT: ;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iptr_q <= IPTR0;
    end else if (iptr_en) begin
      iptr_q <= iptr_d;
    end
  end

  assert_fetch_then_exec_R13: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |=> step);

  assert_load_three_cycles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |=> (!imem_req ##1 imem_req));

  assert_mem_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_re && dmem_we));

  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && $stable(imem_addr)));

  assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!imem_req && !dmem_re && !dmem_we && !step));

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && fn == FN_J) |=>
      (imem_addr == $past(imem_addr) + IADDR_W'(1) + $past(opnd[IADDR_W-1:0])));
endmodule

// File: rtl/nibble_decoder.sv
module nibble_decoder
  import nid_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IADDR_W    = 16,
  parameter int DADDR_W    = 16,
  parameter int IPTR_RESET = 0,
  parameter int WPTR_RESET = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               imem_req,
  output logic [IADDR_W-1:0] imem_addr,
  input  logic [7:0]         imem_rdata,
  output logic               dmem_re,
  output logic               dmem_we,
  output logic [DADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic [DATA_W-1:0]  stk_a,
  output logic [DATA_W-1:0]  stk_b,
  output logic [DATA_W-1:0]  stk_c,
  output logic               error
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              step;
  logic [3:0]        fn;
  logic [3:0]        nibble;
  logic [DATA_W-1:0] opnd;
  stk_op_t           stk_op;
  logic [DATA_W-1:0] stk_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  nid_ctrl #(
    .DATA_W(DATA_W), .IADDR_W(IADDR_W), .DADDR_W(DADDR_W),
    .IPTR_RESET(IPTR_RESET), .WPTR_RESET(WPTR_RESET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .imem_rdata(imem_rdata), .dmem_rdata(dmem_rdata),
    .opnd(opnd), .stk_a(stk_a), .stk_b(stk_b),
    .imem_req(imem_req), .imem_addr(imem_addr),
    .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .step(step), .fn(fn), .nibble(nibble),
    .stk_op(stk_op), .stk_val(stk_val), .error(error)
  );

  nid_operand #(.DATA_W(DATA_W)) u_operand (
    .clk(clk), .rst_n(rst_sync_n), .step(step),
    .fn(fn), .nibble(nibble), .opnd(opnd)
  );

  nid_stack #(.DATA_W(DATA_W)) u_stack (
    .clk(clk), .rst_n(rst_sync_n), .op(stk_op), .val(stk_val),
    .a(stk_a), .b(stk_b), .c(stk_c)
  );
endmodule

// File: tb/nibble_decoder_tb.sv
module nibble_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req;
  logic [15:0] imem_addr;
  logic [7:0]  imem_rdata;
  logic        dmem_re, dmem_we;
  logic [15:0] dmem_addr;
  logic [31:0] dmem_wdata, dmem_rdata;
  logic [31:0] stk_a, stk_b, stk_c;
  logic        error;

  logic [7:0]  rom [0:63];
  logic [31:0] dram [0:31];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  nibble_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_re(dmem_re), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c), .error(error)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (imem_req) imem_rdata <= rom[imem_addr[5:0]];
    if (dmem_re) dmem_rdata <= dram[dmem_addr[4:0]];
    if (dmem_we) dram[dmem_addr[4:0]] <= dmem_wdata;
  end

  typedef struct packed {
    logic [47:0] prog;
    logic [3:0]  len;
    logic [31:0] ea, eb, ec;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{48'h45_00_00_00_00_00, 4'd1, 32'h5, 32'h0, 32'h0},            // R2
    '{48'h41_42_43_00_00_00, 4'd3, 32'h3, 32'h2, 32'h1},            // R2
    '{48'h21_22_43_00_00_00, 4'd3, 32'h123, 32'h0, 32'h0},          // R3
    '{48'h61_45_00_00_00_00, 4'd2, 32'hFFFF_FFE5, 32'h0, 32'h0},    // R4
    '{48'h21_43_47_00_00_00, 4'd3, 32'h7, 32'h13, 32'h0},           // R5
    '{48'h45_60_8F_00_00_00, 4'd3, 32'h4, 32'h0, 32'h0},            // R6
    '{48'h41_42_F0_00_00_00, 4'd3, 32'h1, 32'h2, 32'h0},            // R10
    '{48'h41_43_44_F5_00_00, 4'd4, 32'h7, 32'h1, 32'h1},            // R11 add
    '{48'h41_49_42_20_FC_00, 4'd5, 32'h7, 32'h1, 32'h1},            // R11 sub
    '{48'h43_45_FC_00_00_00, 4'd3, 32'hFFFF_FFFE, 32'h0, 32'h0},    // R11 sub wrap
    '{48'h41_01_42_43_00_00, 4'd4, 32'h3, 32'h1, 32'h0}             // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Loads bytes then a two-byte loop (nfix 0, jump -2) that leaves the stack alone.
  task automatic load_prog(input logic [47:0] p, input int len);
    rst_n = 1'b0;
    for (int k = 0; k < 64; k++) rom[k] = 8'h00;
    for (int k = 0; k < 6; k++) if (k < len) rom[k] = p[47-8*k -: 8];
    rom[len]   = 8'h60;
    rom[len+1] = 8'h0E;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R13 watchdog actual=%0d cycles expected=completion", cyc);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 32; k++) dram[k] = 32'h0;

    // R1: reset state
    load_prog(48'h45_00_00_00_00_00, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 a in reset", stk_a, 32'h0);
    chk("R1 err in reset", {31'b0, error}, 32'h0);
    chk("R1 iptr in reset", {16'h0, imem_addr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 b after release", stk_b, 32'h0);
    chk("R1 c after release", stk_c, 32'h0);

    // Table of programs
    for (int i = 0; i < NV; i++) begin
      load_prog(VEC[i].prog, int'(VEC[i].len));
      repeat (40) @(negedge clk);
      chk($sformatf("vector %0d A", i), stk_a, VEC[i].ea);
      chk($sformatf("vector %0d B", i), stk_b, VEC[i].eb);
      chk($sformatf("vector %0d C", i), stk_c, VEC[i].ec);
      chk($sformatf("vector %0d no error", i), {31'b0, error}, 32'h0);
    end

    // R13: ordinary instruction timing; fetch at N2, execute at N3, result at N4
    load_prog(48'h45_00_00_00_00_00, 1);
    repeat (2) @(negedge clk);
    chk("R13 fetch request", {31'b0, imem_req}, 32'h1);
    @(negedge clk);
    chk("R13 exec cycle A unchanged", stk_a, 32'h0);
    chk("R13 exec cycle no fetch", {31'b0, imem_req}, 32'h0);
    @(negedge clk);
    chk("R13 result visible", stk_a, 32'h5);
    chk("R13 next fetch", {31'b0, imem_req}, 32'h1);

    // R7: load local timing and address
    dram[10] = 32'h55;
    load_prog(48'h72_41_D3_00_00_00, 3);
    repeat (2) @(negedge clk);
    chk("R7 fetch request", {31'b0, imem_req}, 32'h1);
    @(negedge clk);
    chk("R7 read strobe", {31'b0, dmem_re}, 32'h1);
    chk("R7 read address", {16'h0, dmem_addr}, 32'd10);
    @(negedge clk);
    chk("R7 wait cycle A unchanged", stk_a, 32'h0);
    chk("R7 wait cycle no fetch", {31'b0, imem_req}, 32'h0);
    @(negedge clk);
    chk("R7 loaded", stk_a, 32'h55);
    chk("R7 fetch resumes", {31'b0, imem_req}, 32'h1);

    // R8: store local (same program continues)
    repeat (40) @(negedge clk);
    chk("R8 stored word", dram[11], 32'h1);
    chk("R8 pop A", stk_a, 32'h55);
    chk("R8 pop B", stk_b, 32'h0);

    // R8: pop leaves C
    load_prog(48'h41_42_43_D0_00_00, 4);
    repeat (40) @(negedge clk);
    chk("R8 stored top", dram[8], 32'h3);
    chk("R8 A", stk_a, 32'h2);
    chk("R8 B", stk_b, 32'h1);
    chk("R8 C kept", stk_c, 32'h1);

    // R12: undefined operate code
    load_prog(48'h43_F7_44_00_00_00, 3);
    repeat (40) @(negedge clk);
    chk("R12 error raised", {31'b0, error}, 32'h1);
    chk("R12 stack frozen", stk_a, 32'h3);
    chk("R12 iptr at fault", {16'h0, imem_addr}, 32'h1);
    begin
      int seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (imem_req || !error) seen++;
      end
      chk("R12 no fetch while halted", seen, 0);
    end

    // R12: undefined primary function
    load_prog(48'h41_15_42_00_00_00, 3);
    repeat (40) @(negedge clk);
    chk("R12 primary error", {31'b0, error}, 32'h1);
    chk("R12 primary A", stk_a, 32'h1);
    chk("R12 primary B", stk_b, 32'h0);
    chk("R12 primary iptr", {16'h0, imem_addr}, 32'h1);

    // R1: reset clears the error
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears error", {31'b0, error}, 32'h0);
    chk("R1 reset clears A", stk_a, 32'h0);

    finish_run();
  end
endmodule